// File: doc/BRIEF.md
# I/O Page Table Walker

This block turns a device's I/O virtual address (IOVA) into a system physical address. It walks a multi-level I/O page table in memory. A request arrives together with the 64-bit root word of an already validated device table entry, plus the device ID, domain ID, requested access and operation kind. The walker first judges the root word on its own. That alone may settle the request: translation off, pass-through, an unsupported depth or missing root permission. Otherwise it fetches one 64-bit table entry per step through a read port that allows one outstanding request and has a separate response.

Each fetched entry is checked for presence, permission and a sane next-level code. The next-level field picks the table level of the following step, so intermediate levels can be skipped. The walk ends in one of two ways:
- A leaf, which yields the physical address and the permissions accumulated along the path.
- A fault descriptor, carrying a kind code, present and permission-denied flags, an address, the request's IDs and operation flags.

A one-cycle `done` pulse marks the end of every request. The result stays on the outputs until the next request is accepted.

Top module: `iopt_walker`

## Requirements
- R1: When bit 1 (translation valid) of the root word is 0, the walker issues no memory read and reports fault kind 1 (translation off) with present=0, denied=0 and fault address = IOVA.
- R2: When the root level field (bits 11:9) is 0, the walker issues no memory read. If the access bits (req_acc bit 0 = read, bit 1 = write) are all covered by the root permission bits (bit 61 = read, bit 62 = write), it returns res_ok=1 with res_spa = IOVA and res_perm = root permissions. Otherwise it reports fault kind 3 with present=1 and denied=1.
- R3: A root level field above MAX_LVL (default 6) ends the request with fault kind 4 (bad level), present=1 and denied=0, and no memory read.
- R4: When the root level is valid and nonzero but the requested access is not covered by the root permission bits, the walker reports fault kind 3 with present=1 and denied=1, and no memory read.
- R5: The entry address at level L is the current table base (bits 51:12 of the root word or of the previous entry) plus 8 times the 9-bit IOVA field that starts at bit 12, 21, 30, 39, 48 or 57 for L = 1 to 6. The first read uses the root level, and each later read uses the previous entry's next-level field.
- R6: A response with mem_rsp_err=1 ends the walk with fault kind 5 (table read error, a target abort). The fault address is the address of the entry that failed to read, with present=0 and denied=0.
- R7: A fetched entry with bit 0 (present) clear ends the walk with fault kind 2, present=0, denied=0 and fault address = IOVA.
- R8: A present entry whose permission bits (61 read, 62 write) do not cover the requested access ends the walk at that level with fault kind 3, present=1 and denied=1. No further read is issued.
- R9: An entry whose next-level field (bits 11:9) is 0 or 7 is a leaf. The result is res_ok=1, res_spa = the leaf's bits 51:12 above the current level's shift combined with the IOVA bits below that shift, and res_perm = the AND of the root permissions and every fetched entry's permissions.
- R10: A non-leaf entry whose next-level value is greater than MAX_LVL, or not lower than the current level, ends the walk with fault kind 4, present=1 and denied=0.
- R11: At most one memory read is outstanding at any time. The request address stays stable while the request waits for mem_req_ready, and no read is requested while the walker is idle.
- R12: After reset, req_ready=1, done=0 and flt_kind=0. `done` is a one-cycle pulse with res_ok=1 exactly when flt_kind=0, and all result outputs hold until the next accepted request. flt_dev_id and flt_dom_id echo the request's IDs, flt_write = (req_op==1), and flt_xlate = (req_op==2).
- R13: A result decided by the root word alone raises `done` at the first clock edge after the accepting edge. A walk result raises `done` at the same edge that takes the terminal memory response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_dev_id | input | DEV_W | Requesting device ID |
| req_dom_id | input | DOM_W | Domain ID from the device table entry |
| req_iova | input | 64 | I/O virtual address |
| req_acc | input | 2 | Requested access: bit 0 read, bit 1 write |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 translate, 3 other |
| req_root | input | 64 | Root word of the device table entry |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Entry read from memory |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle end-of-request pulse |
| res_ok | output | 1 | Translation succeeded |
| res_spa | output | 64 | Translated physical address |
| res_perm | output | 2 | Granted permissions (bit 0 read, bit 1 write) |
| flt_kind | output | 3 | Fault kind, 0 when none |
| flt_present | output | 1 | Fault present flag |
| flt_denied | output | 1 | Fault permission-denied flag |
| flt_addr | output | 64 | IOVA, or entry address for kind 5 |
| flt_dev_id | output | DEV_W | Device ID of the request |
| flt_dom_id | output | DOM_W | Domain ID of the request |
| flt_write | output | 1 | Request was a memory write |
| flt_xlate | output | 1 | Request was a translation request |

## Verification
Outcomes decided by the root word are due at the first clock edge after the one that accepts the request. A walk outcome is due at the very edge that takes the last memory response. The bench stamps the cycle of each acceptance, and its memory model stamps the cycle in which it offers each response. When `done` appears, the scoreboard monitor compares the current cycle with the stamp the expected item calls for. It also compares how many reads were issued, which catches extra or missing steps. Memory ready and response delays vary from read to read, so the walk timing is checked against changing latencies.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    localparam int ENT_W    = 64;
    localparam int IDX_W    = 9;
    localparam int PAGE_SH  = 12;
    localparam int LVL_W    = 3;
    localparam int PERM_LO  = 61;
    localparam int LVL_LO   = 9;
    localparam logic [ENT_W-1:0] BASE_MASK = 64'h000F_FFFF_FFFF_F000;

    typedef enum logic [2:0] {
        FK_NONE        = 3'd0,
        FK_XLATE_OFF   = 3'd1,
        FK_NOT_PRESENT = 3'd2,
        FK_PERM        = 3'd3,
        FK_BAD_LEVEL   = 3'd4,
        FK_HW_ERR      = 3'd5
    } fault_kind_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_XLATE = 2'd2,
        OP_OTHER = 2'd3
    } op_e;

    typedef struct packed {
        fault_kind_e kind;
        logic        present;
        logic        denied;
    } verdict_t;

    function automatic logic [1:0] ent_perm(input logic [ENT_W-1:0] e);
        return e[PERM_LO+1:PERM_LO];
    endfunction

    function automatic logic [LVL_W-1:0] ent_lvl(input logic [ENT_W-1:0] e);
        return e[LVL_LO+LVL_W-1:LVL_LO];
    endfunction

    function automatic logic [5:0] lvl_shift(input logic [LVL_W-1:0] lvl);
        if (lvl == '0) return 6'd0;
        return 6'(PAGE_SH + IDX_W * (int'(lvl) - 1));
    endfunction

    function automatic logic [ENT_W-1:0] entry_addr(input logic [ENT_W-1:0] tbl,
                                                    input logic [ENT_W-1:0] iova,
                                                    input logic [LVL_W-1:0] lvl);
        logic [ENT_W-1:0] idx;
        idx = (iova >> lvl_shift(lvl)) & ENT_W'((1 << IDX_W) - 1);
        return (tbl & BASE_MASK) + (idx << 3);
    endfunction

    function automatic logic [ENT_W-1:0] leaf_spa(input logic [ENT_W-1:0] ent,
                                                  input logic [ENT_W-1:0] iova,
                                                  input logic [LVL_W-1:0] lvl);
        logic [ENT_W-1:0] low;
        low = (ENT_W'(1) << lvl_shift(lvl)) - ENT_W'(1);
        return ((ent & BASE_MASK) & ~low) | (iova & low);
    endfunction

endpackage

// File: rtl/iopt_root_check.sv
module iopt_root_check
    import iopt_pkg::*;
#(
    parameter int MAX_LVL = 6
) (
    input  logic [ENT_W-1:0] root,
    input  logic [1:0]       acc,
    output verdict_t         verdict,
    output logic             pass,
    output logic             walk
);
    logic [LVL_W-1:0] mode;
    logic             perm_ok;
    logic             unused_root;

    assign mode        = ent_lvl(root);
    assign perm_ok     = (acc & ent_perm(root)) == acc;
    assign unused_root = ^{root[ENT_W-1], root[PERM_LO-1:LVL_LO+LVL_W], root[LVL_LO-1:2], root[0]};

    always_comb begin
        verdict = '{kind: FK_NONE, present: 1'b0, denied: 1'b0};
        pass    = 1'b0;
        walk    = 1'b0;
        if (!root[1]) begin
            verdict.kind = FK_XLATE_OFF;
        end else if (mode == '0) begin
            if (perm_ok) pass = 1'b1;
            else verdict = '{kind: FK_PERM, present: 1'b1, denied: 1'b1};
        end else if (mode > LVL_W'(MAX_LVL)) begin
            verdict = '{kind: FK_BAD_LEVEL, present: 1'b1, denied: 1'b0};
        end else if (!perm_ok) begin
            verdict = '{kind: FK_PERM, present: 1'b1, denied: 1'b1};
        end else begin
            walk = 1'b1;
        end
    end
endmodule

// File: rtl/iopt_entry_check.sv
module iopt_entry_check
    import iopt_pkg::*;
#(
    parameter int MAX_LVL = 6
) (
    input  logic [ENT_W-1:0] ent,
    input  logic             err,
    input  logic [1:0]       acc,
    input  logic [LVL_W-1:0] cur_lvl,
    output verdict_t         verdict,
    output logic             leaf,
    output logic             descend
);
    logic [LVL_W-1:0] nl;
    logic             unused_ent;

    assign nl         = ent_lvl(ent);
    assign unused_ent = ^{ent[ENT_W-1], ent[PERM_LO-1:LVL_LO+LVL_W], ent[LVL_LO-1:1]};

    always_comb begin
        verdict = '{kind: FK_NONE, present: 1'b0, denied: 1'b0};
        leaf    = 1'b0;
        descend = 1'b0;
        if (err) begin
            verdict.kind = FK_HW_ERR;
        end else if (!ent[0]) begin
            verdict.kind = FK_NOT_PRESENT;
        end else if ((acc & ent_perm(ent)) != acc) begin
            verdict = '{kind: FK_PERM, present: 1'b1, denied: 1'b1};
        end else if (nl == '0 || nl == '1) begin
            leaf = 1'b1;
        end else if (nl > LVL_W'(MAX_LVL) || nl >= cur_lvl) begin
            verdict = '{kind: FK_BAD_LEVEL, present: 1'b1, denied: 1'b0};
        end else begin
            descend = 1'b1;
        end
    end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import iopt_pkg::*;
#(
    parameter int MAX_LVL = 6,
    parameter int DEV_W   = 16,
    parameter int DOM_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [DEV_W-1:0] req_dev_id,
    input  logic [DOM_W-1:0] req_dom_id,
    input  logic [63:0]      req_iova,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_op,
    input  logic [63:0]      req_root,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [63:0]      mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    input  logic             mem_rsp_err,
    output logic             done,
    output logic             res_ok,
    output logic [63:0]      res_spa,
    output logic [1:0]       res_perm,
    output logic [2:0]       flt_kind,
    output logic             flt_present,
    output logic             flt_denied,
    output logic [63:0]      flt_addr,
    output logic [DEV_W-1:0] flt_dev_id,
    output logic [DOM_W-1:0] flt_dom_id,
    output logic             flt_write,
    output logic             flt_xlate
);
    typedef enum logic [1:0] {S_IDLE, S_ROOT, S_ISSUE, S_WAIT} state_e;

    state_e           state;
    logic [DEV_W-1:0] dev_q;
    logic [DOM_W-1:0] dom_q;
    logic [63:0]      iova_q;
    logic [1:0]       acc_q;
    op_e              op_q;
    logic [63:0]      root_q;
    logic [63:0]      tbl_q;
    logic [LVL_W-1:0] lvl_q;
    logic [1:0]       perm_q;
    fault_kind_e      kind_q;

    verdict_t         root_v, ent_v;
    logic             root_pass, root_walk, ent_leaf, ent_descend;

    iopt_root_check #(.MAX_LVL(MAX_LVL)) root_chk_i (
        .root(root_q), .acc(acc_q), .verdict(root_v), .pass(root_pass), .walk(root_walk)
    );

    iopt_entry_check #(.MAX_LVL(MAX_LVL)) ent_chk_i (
        .ent(mem_rsp_data), .err(mem_rsp_err), .acc(acc_q), .cur_lvl(lvl_q),
        .verdict(ent_v), .leaf(ent_leaf), .descend(ent_descend)
    );

    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_ISSUE);
    assign mem_req_addr  = entry_addr(tbl_q, iova_q, lvl_q);
    assign flt_kind      = kind_q;
    assign flt_dev_id    = dev_q;
    assign flt_dom_id    = dom_q;
    assign flt_write     = (op_q == OP_WR);
    assign flt_xlate     = (op_q == OP_XLATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            dev_q       <= '0;
            dom_q       <= '0;
            iova_q      <= '0;
            acc_q       <= '0;
            op_q        <= OP_RD;
            root_q      <= '0;
            tbl_q       <= '0;
            lvl_q       <= '0;
            perm_q      <= '0;
            kind_q      <= FK_NONE;
            done        <= 1'b0;
            res_ok      <= 1'b0;
            res_spa     <= '0;
            res_perm    <= '0;
            flt_present <= 1'b0;
            flt_denied  <= 1'b0;
            flt_addr    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    dev_q       <= req_dev_id;
                    dom_q       <= req_dom_id;
                    iova_q      <= req_iova;
                    acc_q       <= req_acc;
                    op_q        <= op_e'(req_op);
                    root_q      <= req_root;
                    kind_q      <= FK_NONE;
                    res_ok      <= 1'b0;
                    res_spa     <= '0;
                    res_perm    <= '0;
                    flt_present <= 1'b0;
                    flt_denied  <= 1'b0;
                    flt_addr    <= '0;
                    state       <= S_ROOT;
                end
                S_ROOT: begin
                    if (root_walk) begin
                        tbl_q  <= root_q;
                        lvl_q  <= ent_lvl(root_q);
                        perm_q <= ent_perm(root_q);
                        state  <= S_ISSUE;
                    end else begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                        if (root_pass) begin
                            res_ok   <= 1'b1;
                            res_spa  <= iova_q;
                            res_perm <= ent_perm(root_q);
                        end else begin
                            kind_q      <= root_v.kind;
                            flt_present <= root_v.present;
                            flt_denied  <= root_v.denied;
                            flt_addr    <= iova_q;
                        end
                    end
                end
                S_ISSUE: if (mem_req_ready) state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    if (ent_descend) begin
                        tbl_q  <= mem_rsp_data;
                        lvl_q  <= ent_lvl(mem_rsp_data);
                        perm_q <= perm_q & ent_perm(mem_rsp_data);
                        state  <= S_ISSUE;
                    end else begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                        if (ent_leaf) begin
                            res_ok   <= 1'b1;
                            res_spa  <= leaf_spa(mem_rsp_data, iova_q, lvl_q);
                            res_perm <= perm_q & ent_perm(mem_rsp_data);
                        end else begin
                            kind_q      <= ent_v.kind;
                            flt_present <= ent_v.present;
                            flt_denied  <= ent_v.denied;
                            flt_addr    <= (ent_v.kind == FK_HW_ERR) ? mem_req_addr : iova_q;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk #(
    parameter int MAX_LVL = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_iova,
    input logic [63:0] req_root,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        done,
    input logic        res_ok,
    input logic [63:0] res_spa,
    input logic [2:0]  flt_kind,
    input logic        flt_present,
    input logic        flt_denied
);
    logic accept;
    assign accept = req_valid && req_ready;

    p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_ok_matches_kind_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (res_ok == (flt_kind == 3'd0)));

    p_hold_result_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready && !req_valid |=> $stable(flt_kind) && $stable(res_ok) && $stable(res_spa));

    p_xlate_off_r1: assert property (@(posedge clk) disable iff (rst)
        accept && !req_root[1] |=> ##1 done && flt_kind == 3'd1 && !flt_present);

    p_pass_spa_r2: assert property (@(posedge clk) disable iff (rst)
        accept && req_root[1] && req_root[11:9] == 3'd0
        |=> ##1 done && (!res_ok || res_spa == $past(req_iova, 2)));

    p_bad_mode_r3: assert property (@(posedge clk) disable iff (rst)
        accept && req_root[1] && req_root[11:9] > 3'(MAX_LVL)
        |=> ##1 done && flt_kind == 3'd4 && flt_present);

    p_denied_present_r8: assert property (@(posedge clk) disable iff (rst)
        done && flt_denied |-> flt_present);
endmodule

bind iopt_walker iopt_walker_chk #(.MAX_LVL(MAX_LVL)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_iova(req_iova), .req_root(req_root), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .done(done),
    .res_ok(res_ok), .res_spa(res_spa), .flt_kind(flt_kind),
    .flt_present(flt_present), .flt_denied(flt_denied)
);

// File: tb/iopt_walker_tb_top.sv
module iopt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_dev_id = '0;
    logic [15:0] req_dom_id = '0;
    logic [63:0] req_iova = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_op = '0;
    logic [63:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done, res_ok;
    logic [63:0] res_spa, flt_addr;
    logic [1:0]  res_perm;
    logic [2:0]  flt_kind;
    logic        flt_present, flt_denied, flt_write, flt_xlate;
    logic [15:0] flt_dev_id, flt_dom_id;

    always #4 clk = ~clk;

    iopt_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev_id(req_dev_id), .req_dom_id(req_dom_id), .req_iova(req_iova),
        .req_acc(req_acc), .req_op(req_op), .req_root(req_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .res_ok(res_ok), .res_spa(res_spa), .res_perm(res_perm),
        .flt_kind(flt_kind), .flt_present(flt_present), .flt_denied(flt_denied),
        .flt_addr(flt_addr), .flt_dev_id(flt_dev_id), .flt_dom_id(flt_dom_id),
        .flt_write(flt_write), .flt_xlate(flt_xlate)
    );

    typedef struct {
        string       tag;
        logic        ok;
        logic [63:0] spa;
        logic [1:0]  perm;
        logic [2:0]  kind;
        logic        present;
        logic        denied;
        logic [63:0] addr;
        logic [15:0] dev;
        logic [15:0] dom;
        logic        wr;
        logic        xl;
        int          reads;
        bit          walked;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    int          acc_cyc = 0;
    int          last_rsp_cyc = 0;
    int          rd_cnt = 0;
    int          rd_start = 0;
    logic [63:0] mem [logic [63:0]];
    bit          errs [logic [63:0]];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit cond, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [63:0] mk_root(input bit tv, input int mode,
                                            input logic [63:0] base, input logic [1:0] perm);
        return (64'(tv) << 1) | 64'd1 | (64'(mode) << 9) | base | (64'(perm) << 61);
    endfunction

    function automatic logic [63:0] mk_ent(input bit p, input int nl,
                                           input logic [63:0] base, input logic [1:0] perm);
        return 64'(p) | (64'(nl) << 9) | base | (64'(perm) << 61);
    endfunction

    // memory model: one read at a time, varying ready and response delays
    initial begin
        logic [63:0] a;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (rd_cnt % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                a = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                rd_cnt++;
                repeat (rd_cnt % 2) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'd0;
                mem_rsp_err   = errs.exists(a);
                last_rsp_cyc  = cyc + 1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
        end
    end

    // monitor: compare each finished request against the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(res_ok == e.ok, e.tag, "res_ok", 64'(res_ok), 64'(e.ok));
                    check(flt_kind == e.kind, e.tag, "flt_kind", 64'(flt_kind), 64'(e.kind));
                    if (e.ok) begin
                        check(res_spa == e.spa, e.tag, "res_spa", res_spa, e.spa);
                        check(res_perm == e.perm, e.tag, "res_perm", 64'(res_perm), 64'(e.perm));
                    end else begin
                        check(flt_present == e.present, e.tag, "flt_present", 64'(flt_present), 64'(e.present));
                        check(flt_denied == e.denied, e.tag, "flt_denied", 64'(flt_denied), 64'(e.denied));
                        check(flt_addr == e.addr, e.tag, "flt_addr", flt_addr, e.addr);
                    end
                    check(flt_dev_id == e.dev && flt_dom_id == e.dom, "R12", "ids",
                          {32'd0, flt_dev_id, flt_dom_id}, {32'd0, e.dev, e.dom});
                    check(flt_write == e.wr && flt_xlate == e.xl, "R12", "op flags",
                          64'({flt_write, flt_xlate}), 64'({e.wr, e.xl}));
                    check(rd_cnt - rd_start == e.reads, e.tag, "read count",
                          64'(rd_cnt - rd_start), 64'(e.reads));
                    if (e.walked)
                        check(cyc == last_rsp_cyc, "R13", "walk done cycle", 64'(cyc), 64'(last_rsp_cyc));
                    else
                        check(cyc == acc_cyc + 1, "R13", "root done cycle", 64'(cyc), 64'(acc_cyc + 1));
                end
            end
        end
    end

    task automatic run(input string tag, input logic [63:0] iova, input logic [1:0] acc,
                       input logic [1:0] op, input logic [63:0] root, input logic ok,
                       input logic [63:0] spa, input logic [1:0] perm, input logic [2:0] kind,
                       input logic present, input logic denied, input logic [63:0] faddr,
                       input int reads, input bit walked);
        exp_t e;
        e.tag = tag; e.ok = ok; e.spa = spa; e.perm = perm; e.kind = kind;
        e.present = present; e.denied = denied; e.addr = faddr;
        e.dev = 16'(16'h0100 + checks); e.dom = 16'(16'h0A00 + checks);
        e.wr = (op == 2'd1); e.xl = (op == 2'd2);
        e.reads = reads; e.walked = walked;
        @(negedge clk);
        exp_q.push_back(e);
        rd_start   = rd_cnt;
        req_dev_id = e.dev;
        req_dom_id = e.dom;
        req_iova   = iova;
        req_acc    = acc;
        req_op     = op;
        req_root   = root;
        req_valid  = 1'b1;
        acc_cyc    = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        mem[64'h10008] = mk_ent(1, 2, 64'h20000, 2'b11);
        mem[64'h20010] = mk_ent(1, 1, 64'h30000, 2'b11);
        mem[64'h30018] = mk_ent(1, 0, 64'hABCDE000, 2'b01);
        mem[64'h40028] = mk_ent(1, 1, 64'h50000, 2'b11);
        mem[64'h50038] = mk_ent(1, 7, 64'h123456000, 2'b11);
        mem[64'h60020] = mk_ent(1, 0, 64'h700000000, 2'b11);
        errs[64'h80048] = 1'b1;
        mem[64'h90000] = mk_ent(1, 3, 64'h91000, 2'b11);
        mem[64'hA0008] = mk_ent(1, 1, 64'hB0000, 2'b11);
        mem[64'hB0000] = mk_ent(1, 0, 64'hC000, 2'b11);
        mem[64'hD0008] = mk_ent(1, 1, 64'hE0000, 2'b01);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R12", "reset outputs",
              64'({req_ready, done, mem_req_valid}), 64'b100);
        check(flt_kind == 3'd0, "R12", "reset flt_kind", 64'(flt_kind), 64'd0);

        // R1: translation valid clear
        run("R1", 64'h5000, 2'b01, 2'd0, mk_root(0, 3, 64'h10000, 2'b11),
            0, 0, 0, 3'd1, 0, 0, 64'h5000, 0, 0);
        // R2: pass-through granted and denied
        run("R2", 64'h1234_5678_9ABC, 2'b01, 2'd0, mk_root(1, 0, 0, 2'b01),
            1, 64'h1234_5678_9ABC, 2'b01, 3'd0, 0, 0, 0, 0, 0);
        run("R2", 64'h4444, 2'b10, 2'd1, mk_root(1, 0, 0, 2'b01),
            0, 0, 0, 3'd3, 1, 1, 64'h4444, 0, 0);
        // R3: root level beyond the maximum
        run("R3", 64'h7777, 2'b01, 2'd0, mk_root(1, 7, 0, 2'b11),
            0, 0, 0, 3'd4, 1, 0, 64'h7777, 0, 0);
        // R4: root permission lacks write
        run("R4", 64'h8888, 2'b10, 2'd1, mk_root(1, 3, 64'h10000, 2'b01),
            0, 0, 0, 3'd3, 1, 1, 64'h8888, 0, 0);
        // R5 R9: three-level walk to a 4 KiB leaf
        run("R5_R9", 64'h4040_3123, 2'b01, 2'd0, mk_root(1, 3, 64'h10000, 2'b11),
            1, 64'hABCDE123, 2'b01, 3'd0, 0, 0, 0, 3, 1);
        // R8: leaf lacks write permission
        run("R8", 64'h4040_3123, 2'b10, 2'd1, mk_root(1, 3, 64'h10000, 2'b11),
            0, 0, 0, 3'd3, 1, 1, 64'h4040_3123, 3, 1);
        // R8: intermediate entry lacks write, walk stops after one read
        run("R8", 64'h0020_0000, 2'b10, 2'd1, mk_root(1, 2, 64'hD0000, 2'b11),
            0, 0, 0, 3'd3, 1, 1, 64'h0020_0000, 1, 1);
        // R5 R9: level skip from 4 to 1, leaf code 7
        run("R5_R9", (64'd5 << 39) | 64'h70AB, 2'b11, 2'd2, mk_root(1, 4, 64'h40000, 2'b11),
            1, 64'h1234560AB, 2'b11, 3'd0, 0, 0, 0, 2, 1);
        // R9: leaf at level 2 keeps 21 IOVA bits
        run("R9", (64'd4 << 21) | 64'h12345, 2'b01, 2'd0, mk_root(1, 2, 64'h60000, 2'b11),
            1, 64'h700012345, 2'b11, 3'd0, 0, 0, 0, 1, 1);
        // R7: entry not present
        run("R7", (64'd5 << 21), 2'b01, 2'd2, mk_root(1, 2, 64'h60000, 2'b11),
            0, 0, 0, 3'd2, 0, 0, (64'd5 << 21), 1, 1);
        // R6: read error reports entry address
        run("R6", (64'd9 << 12), 2'b01, 2'd0, mk_root(1, 1, 64'h80000, 2'b11),
            0, 0, 0, 3'd5, 0, 0, 64'h80048, 1, 1);
        // R10: next level not below current
        run("R10", 64'h0, 2'b01, 2'd3, mk_root(1, 3, 64'h90000, 2'b11),
            0, 0, 0, 3'd4, 1, 0, 64'h0, 1, 1);
        // R5: level 6 index at bit 57
        run("R5", (64'd1 << 57) | 64'h7FF, 2'b01, 2'd0, mk_root(1, 6, 64'hA0000, 2'b11),
            1, 64'hC7FF, 2'b11, 3'd0, 0, 0, 0, 2, 1);

        // R12: results hold while idle
        repeat (4) @(negedge clk);
        check(res_ok == 1'b1 && res_spa == 64'hC7FF, "R12", "held result", res_spa, 64'hC7FF);
        check(req_ready == 1'b1 && mem_req_valid == 1'b0, "R11", "idle no read",
              64'({req_ready, mem_req_valid}), 64'b10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule